// File: doc/BRIEF.md
# Register-Programmed Block Transfer Channel

This block moves a block of words between a device data port and memory without the processor touching each word. The processor sets it up through three registers: the starting memory address, the number of words, and a control/status register. The control/status register holds the direction, the interrupt enable and the transfer mode, and it reports completion. A write with the start bit set launches the transfer. The channel then asks for the system bus and only issues a memory cycle while the bus is granted.

The channel has two transfer modes. In cycle-stealing mode it takes one word per grant and then drops its request for a cycle, so the processor can win the bus back between words. In burst mode it keeps the request up and moves one word on every granted cycle until the count runs out.

At the end of a block the channel sets a done flag. If interrupts are enabled it also raises an interrupt, which stays up until software reads the control/status register. Address and count registers count live during the transfer and can be read back.

Top module: `dma_chan`

## Requirements
- R1: After reset all three registers read as zero, and `bus_req_o` and `irq_o` are low.
- R2: Register select 0 is the address, 1 is the word count and 2 is the control/status word. In the control/status word, bit 0 is the direction (1 = memory to device, 0 = device to memory), bit 1 is the interrupt enable, bit 3 selects burst mode (1) or cycle stealing (0), bit 30 is the interrupt flag and bit 31 is done. Bit 2 is the start command and always reads 0.
- R3: Writing control with bit 2 set while the channel is idle clears done and the interrupt flag. With a non-zero count, `bus_req_o` is high from the next cycle.
- R4: `mem_en_o` is high only in cycles where `bus_gnt_i` is high. No word moves while the grant is withheld.
- R5: Each transferred word advances the address register by one and lowers the count register by one. Both registers read back their live values.
- R6: With direction 1, the memory word at the current address goes to `dev_wdata_o` with `dev_wr_o` high. With direction 0, `dev_rdata_i` is written to memory with `mem_we_o` and `dev_rd_o` high. The words move in address order.
- R7: In cycle-stealing mode, at most one word moves per grant. `bus_req_o` drops for at least one cycle after each word except the last, so a block of N words raises the request N times.
- R8: In burst mode, `bus_req_o` rises once per block. Under a held grant, the N words move in N consecutive cycles.
- R9: When the last word moves, done is set. The interrupt flag and `irq_o` are set one cycle later only if the interrupt enable is 1.
- R10: A start with a count of zero sets done in the next cycle, and sets the interrupt flag if enabled, without ever raising `bus_req_o`.
- R11: A read of the control/status register returns the current flags. It then clears the interrupt flag and `irq_o` from the next cycle, while done stays set.
- R12: While a transfer is in progress, writes to the address, count or control registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_sel_i | input | 2 | Register select (0 address, 1 count, 2 control/status) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on reg_sel_i |
| bus_req_o | output | 1 | System bus request |
| bus_gnt_i | input | 1 | System bus grant |
| mem_en_o | output | 1 | Memory cycle strobe |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | AW (16) | Memory word address |
| mem_wdata_o | output | DW (32) | Memory write data |
| mem_rdata_i | input | DW (32) | Memory read data, same cycle |
| dev_rdata_i | input | DW (32) | Word offered by the device |
| dev_rd_o | output | 1 | Device word consumed |
| dev_wdata_o | output | DW (32) | Word delivered to the device |
| dev_wr_o | output | 1 | Device word valid |
| irq_o | output | 1 | Interrupt output |

## Verification
A start command takes effect at the edge that samples it: the request is visible in the following cycle. The bench arbiter registers the grant, so the first word moves two edges later. Each word is committed at the edge that ends its granted cycle, and its address, count and memory effects are sampled on the next falling edge. Done is readable from the cycle after the last word, and the interrupt one cycle after that. A flag-clearing read is judged at the falling edge one cycle after the read edge. The bench therefore samples every output on a falling edge, counts one cycle per register in the path, and checks mode behaviour through request-rise and word-strobe counts taken by a monitor at each rising edge.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int unsigned REG_W = 32;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_CNT  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  localparam int unsigned CB_DIR   = 0;
  localparam int unsigned CB_IE    = 1;
  localparam int unsigned CB_GO    = 2;
  localparam int unsigned CB_BURST = 3;
  localparam int unsigned CB_IRQ   = 30;
  localparam int unsigned CB_DONE  = 31;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_XFER,
    ST_REL
  } dma_state_e;
endpackage

// File: rtl/dma_cnt.sv
module dma_cnt #(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_addr_i,
  input  logic          ld_cnt_i,
  input  logic [31:0]   wdata_i,
  input  logic          beat_i,
  output logic [AW-1:0] addr_o,
  output logic [CW-1:0] cnt_o,
  output logic          cnt_zero_o,
  output logic          cnt_last_o
);
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (ld_addr_i)   addr_q <= wdata_i[AW-1:0];
      else if (beat_i) addr_q <= addr_q + AW'(1);
      if (ld_cnt_i)    cnt_q  <= wdata_i[CW-1:0];
      else if (beat_i) cnt_q  <= cnt_q - CW'(1);
    end
  end

  assign addr_o     = addr_q;
  assign cnt_o      = cnt_q;
  assign cnt_zero_o = (cnt_q == '0);
  assign cnt_last_o = (cnt_q == CW'(1));

  p_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_i |=> (addr_q == $past(addr_q) + AW'(1)) && (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/dma_fsm.sv
module dma_fsm
  import dma_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic burst_i,
  input  logic cnt_zero_i,
  input  logic cnt_last_i,
  input  logic gnt_i,
  output logic req_o,
  output logic beat_o,
  output logic busy_o,
  output logic finish_o
);
  dma_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i && !cnt_zero_i) state_d = ST_REQ;
      ST_REQ:  if (gnt_i) state_d = ST_XFER;
      ST_XFER: if (gnt_i) begin
        if (cnt_last_i)   state_d = ST_IDLE;
        else if (!burst_i) state_d = ST_REL;
      end
      ST_REL:  state_d = ST_REQ;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign req_o    = (state_q == ST_REQ) || (state_q == ST_XFER);
  assign beat_o   = (state_q == ST_XFER) && gnt_i;
  assign busy_o   = (state_q != ST_IDLE);
  assign finish_o = (beat_o && cnt_last_i) || (start_i && cnt_zero_i && !busy_o);

  p_start_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !cnt_zero_i && !busy_o) |=> req_o);
  p_steal_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_o && !burst_i && !cnt_last_i) |=> !req_o);
  p_burst_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_o && burst_i && !cnt_last_i) |=> req_o);
  p_zero_noreq_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && cnt_zero_i && !busy_o) |=> !req_o);
endmodule

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       sel_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic [AW-1:0]    addr_i,
  input  logic [CW-1:0]    cnt_i,
  input  logic             busy_i,
  input  logic             finish_i,
  output logic             ld_addr_o,
  output logic             ld_cnt_o,
  output logic             start_o,
  output logic             dir_o,
  output logic             burst_o,
  output logic             irq_o
);
  logic dir_q, ie_q, burst_q, irq_q, done_q;
  logic wr_ok, ctrl_wr, ctrl_rd;

  assign wr_ok     = wr_i && !busy_i;
  assign ld_addr_o = wr_ok && (sel_i == SEL_ADDR);
  assign ld_cnt_o  = wr_ok && (sel_i == SEL_CNT);
  assign ctrl_wr   = wr_ok && (sel_i == SEL_CTRL);
  assign ctrl_rd   = rd_i && (sel_i == SEL_CTRL);
  assign start_o   = ctrl_wr && wdata_i[CB_GO];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q   <= 1'b0;
      ie_q    <= 1'b0;
      burst_q <= 1'b0;
    end else if (ctrl_wr) begin
      dir_q   <= wdata_i[CB_DIR];
      ie_q    <= wdata_i[CB_IE];
      burst_q <= wdata_i[CB_BURST];
    end
  end

  // done sets with the last word; irq follows one cycle later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (finish_i && !busy_i)  done_q <= 1'b1;
      else if (finish_i)        done_q <= 1'b1;
      else if (start_o)         done_q <= 1'b0;
      if (start_o && !finish_i) irq_q <= 1'b0;
      else if (finish_i && busy_i) irq_q <= irq_q;
      else if (done_set_ie())   irq_q <= 1'b1;
      else if (ctrl_rd)         irq_q <= 1'b0;
    end
  end

  logic fin_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fin_q <= 1'b0;
    else         fin_q <= finish_i && (start_o ? wdata_i[CB_IE] : ie_q);
  end

  function automatic logic done_set_ie();
    return fin_q;
  endfunction

  always_comb begin
    rdata_o = '0;
    unique case (sel_i)
      SEL_ADDR: rdata_o[AW-1:0] = addr_i;
      SEL_CNT:  rdata_o[CW-1:0] = cnt_i;
      SEL_CTRL: begin
        rdata_o[CB_DIR]   = dir_q;
        rdata_o[CB_IE]    = ie_q;
        rdata_o[CB_BURST] = burst_q;
        rdata_o[CB_IRQ]   = irq_q;
        rdata_o[CB_DONE]  = done_q;
      end
      default: rdata_o = '0;
    endcase
  end

  assign dir_o   = dir_q;
  assign burst_o = burst_q;
  assign irq_o   = irq_q;

  p_irq_needs_ie_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> ie_q && done_q);
  p_done_on_finish_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finish_i |=> done_q);
  p_read_clears_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_rd && !fin_q && !start_o) |=> !irq_q);
  p_busy_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(dir_q) && $stable(burst_q));
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    reg_sel_i,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  output logic          bus_req_o,
  input  logic          bus_gnt_i,
  output logic          mem_en_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic [DW-1:0] dev_rdata_i,
  output logic          dev_rd_o,
  output logic [DW-1:0] dev_wdata_o,
  output logic          dev_wr_o,
  output logic          irq_o
);
  logic          ld_addr, ld_cnt, start, dir, burst;
  logic          busy, beat, finish, cnt_zero, cnt_last;
  logic [AW-1:0] addr;
  logic [CW-1:0] cnt;

  dma_regs #(.AW(AW), .CW(CW)) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (reg_sel_i),
    .wr_i     (reg_wr_i),
    .rd_i     (reg_rd_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .addr_i   (addr),
    .cnt_i    (cnt),
    .busy_i   (busy),
    .finish_i (finish),
    .ld_addr_o(ld_addr),
    .ld_cnt_o (ld_cnt),
    .start_o  (start),
    .dir_o    (dir),
    .burst_o  (burst),
    .irq_o    (irq_o)
  );

  dma_cnt #(.AW(AW), .CW(CW)) i_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_addr_i (ld_addr),
    .ld_cnt_i  (ld_cnt),
    .wdata_i   (reg_wdata_i),
    .beat_i    (beat),
    .addr_o    (addr),
    .cnt_o     (cnt),
    .cnt_zero_o(cnt_zero),
    .cnt_last_o(cnt_last)
  );

  dma_fsm i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .burst_i   (burst),
    .cnt_zero_i(cnt_zero),
    .cnt_last_i(cnt_last),
    .gnt_i     (bus_gnt_i),
    .req_o     (bus_req_o),
    .beat_o    (beat),
    .busy_o    (busy),
    .finish_o  (finish)
  );

  assign mem_en_o    = beat;
  assign mem_we_o    = beat && !dir;
  assign mem_addr_o  = addr;
  assign mem_wdata_o = dev_rdata_i;
  assign dev_rd_o    = beat && !dir;
  assign dev_wdata_o = mem_rdata_i;
  assign dev_wr_o    = beat && dir;

  p_mem_needs_gnt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o |-> bus_gnt_i && bus_req_o);
  p_dir_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dev_wr_o && mem_we_o));
endmodule

// File: tb/test_dma_chan.sv
module test_dma_chan;
  localparam int AW = 16, CW = 16, DW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [1:0]    reg_sel = '0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0]   reg_wdata = '0, reg_rdata;
  logic          bus_req, bus_gnt = 1'b0, hold = 1'b0;
  logic          mem_en, mem_we, dev_rd, dev_wr, irq;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, dev_wdata, dev_rdata;

  logic [DW-1:0] mem [64];
  logic [DW-1:0] sink [16];
  int sink_n = 0, src_n = 0;
  int beats = 0, req_rises = 0, first_beat = -1, last_beat = -1, cyc = 0, nogrant = 0;
  logic req_prev = 1'b0;
  int n_chk = 0, n_fail = 0;

  dma_chan #(.AW(AW), .CW(CW), .DW(DW)) i_dma_chan (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_sel_i(reg_sel), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .bus_req_o(bus_req), .bus_gnt_i(bus_gnt),
    .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .dev_rdata_i(dev_rdata), .dev_rd_o(dev_rd),
    .dev_wdata_o(dev_wdata), .dev_wr_o(dev_wr), .irq_o(irq)
  );

  assign mem_rdata = mem[mem_addr[5:0]];
  assign dev_rdata = 32'hA500_0000 + 32'(src_n);

  always_ff @(posedge clk) begin
    cyc <= cyc + 1;
    bus_gnt <= bus_req && !hold;
    req_prev <= bus_req;
    if (bus_req && !req_prev) req_rises <= req_rises + 1;
    if (mem_en && !bus_gnt) nogrant <= nogrant + 1;
    if (mem_en) begin
      beats <= beats + 1;
      if (first_beat < 0) first_beat <= cyc;
      last_beat <= cyc;
      if (mem_we) mem[mem_addr[5:0]] <= mem_wdata;
    end
    if (dev_rd) src_n <= src_n + 1;
    if (dev_wr) begin
      sink[sink_n[3:0]] <= dev_wdata;
      sink_n <= sink_n + 1;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] sel, output logic [31:0] d);
    @(negedge clk); reg_sel = sel; reg_rd = 1'b1; #1 d = reg_rdata;
    @(posedge clk); @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic clr_mon();
    @(negedge clk);
    beats = 0; req_rises = 0; first_beat = -1; last_beat = -1; nogrant = 0;
    sink_n = 0;
  endtask

  task automatic wait_beats(input int n);
    for (int i = 0; i < 500 && beats < n; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk(bus_req == 1'b0 && irq == 1'b0, "R1 req/irq", {30'b0, bus_req, irq}, 32'h0);
    for (int s = 0; s < 3; s++) begin
      rd_reg(2'(s), d);
      chk(d == 32'h0, "R1 reg reset", d, 32'h0);
    end
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr_reg(2'd0, 32'h0000_0010);
    wr_reg(2'd1, 32'h0000_0005);
    wr_reg(2'd2, 32'h0000_000B);
    rd_reg(2'd0, d); chk(d == 32'h10, "R2 addr readback", d, 32'h10);
    rd_reg(2'd1, d); chk(d == 32'h5, "R2 count readback", d, 32'h5);
    rd_reg(2'd2, d); chk(d == 32'hB, "R2 ctrl readback", d, 32'hB);
  endtask

  task automatic t_read_burst();
    logic [31:0] d;
    for (int i = 0; i < 4; i++) mem[16+i] = 32'hC0DE_0000 + 32'(i);
    clr_mon();
    wr_reg(2'd0, 32'h10);
    wr_reg(2'd1, 32'h4);
    wr_reg(2'd2, 32'h0000_000F); // dir=1 ie burst start
    chk(bus_req == 1'b1, "R3 request after start", {31'b0, bus_req}, 32'h1);
    wait_beats(4);
    chk(sink_n == 4, "R6 device words", 32'(sink_n), 32'h4);
    for (int i = 0; i < 4; i++)
      chk(sink[i] == 32'hC0DE_0000 + 32'(i), "R6 device order", sink[i], 32'hC0DE_0000 + 32'(i));
    chk(req_rises == 1, "R8 single request", 32'(req_rises), 32'h1);
    chk(last_beat - first_beat == 3, "R8 back-to-back", 32'(last_beat - first_beat), 32'h3);
    chk(nogrant == 0, "R4 no cycle without grant", 32'(nogrant), 32'h0);
    rd_reg(2'd0, d); chk(d == 32'h14, "R5 address advanced", d, 32'h14);
    rd_reg(2'd1, d); chk(d == 32'h0, "R5 count exhausted", d, 32'h0);
    chk(irq == 1'b1, "R9 irq with enable", {31'b0, irq}, 32'h1);
    rd_reg(2'd2, d);
    chk(d[31:30] == 2'b11, "R9 done and irq flags", {30'b0, d[31:30]}, 32'h3);
    chk(irq == 1'b0, "R11 irq cleared by read", {31'b0, irq}, 32'h0);
    rd_reg(2'd2, d);
    chk(d[31:30] == 2'b10, "R11 done kept", {30'b0, d[31:30]}, 32'h2);
  endtask

  task automatic t_write_steal();
    logic [31:0] d;
    int base;
    clr_mon();
    base = src_n;
    wr_reg(2'd0, 32'h20);
    wr_reg(2'd1, 32'h3);
    wr_reg(2'd2, 32'h0000_0004); // dir=0 no ie steal start
    rd_reg(2'd2, d);
    chk(d[31] == 1'b0, "R3 start clears done", {31'b0, d[31]}, 32'h0);
    wait_beats(3);
    for (int i = 0; i < 3; i++)
      chk(mem[32+i] == 32'hA500_0000 + 32'(base + i), "R6 memory written",
          mem[32+i], 32'hA500_0000 + 32'(base + i));
    chk(req_rises == 3, "R7 one word per grant", 32'(req_rises), 32'h3);
    chk(irq == 1'b0, "R9 no irq when disabled", {31'b0, irq}, 32'h0);
    rd_reg(2'd2, d);
    chk(d[31:30] == 2'b10, "R9 done without irq flag", {30'b0, d[31:30]}, 32'h2);
  endtask

  task automatic t_zero();
    logic [31:0] d;
    clr_mon();
    wr_reg(2'd1, 32'h0);
    wr_reg(2'd2, 32'h0000_0006); // ie start
    @(negedge clk);
    chk(irq == 1'b1, "R10 zero count irq", {31'b0, irq}, 32'h1);
    rd_reg(2'd2, d);
    chk(d[31] == 1'b1, "R10 zero count done", {31'b0, d[31]}, 32'h1);
    chk(req_rises == 0 && beats == 0, "R10 no bus request", 32'(req_rises + beats), 32'h0);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] d;
    clr_mon();
    hold = 1'b1;
    wr_reg(2'd0, 32'h30);
    wr_reg(2'd1, 32'h2);
    wr_reg(2'd2, 32'h0000_000D); // dir=1 burst start
    wr_reg(2'd0, 32'h3F);
    wr_reg(2'd1, 32'h9);
    wr_reg(2'd2, 32'h0000_0002);
    repeat (4) @(negedge clk);
    chk(beats == 0, "R4 held grant blocks transfer", 32'(beats), 32'h0);
    rd_reg(2'd0, d); chk(d == 32'h30, "R12 address kept", d, 32'h30);
    rd_reg(2'd1, d); chk(d == 32'h2, "R12 count kept", d, 32'h2);
    rd_reg(2'd2, d); chk(d[3:0] == 4'h9, "R12 ctrl kept", {28'b0, d[3:0]}, 32'h9);
    hold = 1'b0;
    wait_beats(2);
    chk(beats == 2 && nogrant == 0, "R4 completes after grant", 32'(beats), 32'h2);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_read_burst();
    t_write_steal();
    t_zero();
    t_busy_ignore();
    finish_run();
  end
endmodule